// File: doc/BRIEF.md
# Volume and Source-Select Control Target

This block is the control front end of a two-channel audio trim stage. It listens on a two-wire I2C bus as a write-only target. It holds three 8-bit control registers: the channel A gain, the channel B gain and the source selector. It decodes these registers into outputs that the analog side can use directly. Each channel gets a gain-step index and a mute flag. The selector becomes a one-hot line that enables one of six input pairs.

A bus master addresses the block and writes one register-pointer byte. One or more data bytes follow. After each data byte the pointer advances through the three registers and wraps back to the first one, so a burst can refresh every setting in a single frame. The bus lines are first synchronized to the system clock and then filtered, so that short spikes cannot create false clock edges or false START and STOP conditions. The target never stretches the clock. It never places read data on SDA. It only pulls SDA low to acknowledge bytes.

Top module: `volsel_i2c_target`

## Requirements
- R1: After reset both channels are muted (stored gain code 1111b, so step index 0 and mute flag 1), `src_sel` is 000001b (source 0), and `sda_oe` is 0.
- R2: A frame whose first byte is 1000001b followed by write bit 0 (byte 82h) is acknowledged: `sda_oe` is 1 while SCL is high on the ninth clock.
- R3: A frame whose 7-bit address differs from 1000001b gets no acknowledge on any byte, and none of its bytes changes a register.
- R4: A frame to address 1000001b with read bit 1 (byte 83h) gets no acknowledge, `sda_oe` stays 0 for the whole frame, and no register changes.
- R5: In a write frame, the byte after the address loads the register pointer (0 = gain A, 1 = gain B, 2 = selector). Each data byte is written to the pointed register, and the pointer then advances 0, 1, 2, 0 and so on.
- R6: Gain decode uses bits 3..0 of a gain register, and bits 7..4 have no effect. Code 0 to 8 gives step index equal to the code (0 = +12 dB, each step 3 dB lower, 8 = -12 dB) with mute flag 0. Code 9 to 15 gives mute flag 1 and step index 0.
- R7: Selector decode uses bits 2..0 of the selector register, and bits 7..3 have no effect. Code 0 to 5 sets only `src_sel` bit equal to the code. Codes 6 and 7 leave `src_sel` unchanged.
- R8: A pointer byte of 03h or above is acknowledged, and the data bytes that follow are acknowledged but change no register.
- R9: A pulse of 5 system clocks (50 ns at 100 MHz) or shorter on SCL or SDA is ignored. A frame that carries such pulses writes the same result as a clean frame.
- R10: A repeated START inside a frame restarts the address phase. The next address byte and pointer byte are handled as in a fresh frame.
- R11: After an accepted address, every following byte in the frame is acknowledged, including each byte of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 100 MHz nominal |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pin |
| sda_i | input | 1 | SDA level seen at the pin (wired-AND bus) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge only) |
| vol_a_step | output | 4 | Channel A gain step index, 0 = +12 dB |
| vol_a_mute | output | 1 | Channel A mute |
| vol_b_step | output | 4 | Channel B gain step index, 0 = +12 dB |
| vol_b_mute | output | 1 | Channel B mute |
| src_sel | output | 6 | One-hot input source enable |

## Verification
The assertions assume that the bus master changes SDA only while SCL is low, except when it forms a START or STOP. They also assume that every real SCL or SDA level lasts much longer than the filter window, so the filtered lines move in the same order as the pins. The bench master keeps each quarter bit at 63 clocks, which keeps SCL under 400 kHz. It changes SDA a full quarter bit away from any SCL edge. The only short pulses it makes are the deliberate 5-clock spikes, and these stay inside the rejection window.

// File: rtl/volsel_pkg.sv
// Package volsel_pkg
// Shared constants and types for the volume/source-select I2C target.
// Assumes a system clock near 100 MHz, so that the filter length below
// covers 50 ns spikes.
package volsel_pkg;
    localparam int          BYTE_W        = 8;
    localparam int          ADDR_W        = 7;
    localparam logic [6:0]  TARGET_ADDR   = 7'b1000001;
    localparam int          NUM_REGS      = 3;
    localparam int          PTR_W         = $clog2(NUM_REGS);
    localparam int          NUM_CH        = 2;
    localparam int          VOL_W         = 4;
    localparam logic [3:0]  VOL_MAX_CODE  = 4'd8;
    localparam int          NUM_SRC       = 6;
    localparam int          SRC_CODE_W    = 3;
    localparam int          REG_SRC       = 2;
    localparam int          BITCNT_W      = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_DATA,
        ST_SKIP
    } bus_state_t;

    // Reset value of each register: the gain registers start at all ones,
    // the selector starts at all zeros.
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        return (idx == REG_SRC) ? 8'h00 : 8'hFF;
    endfunction
endpackage

// File: rtl/volsel_line_filter.sv
// Module volsel_line_filter
// Brings one bus line into the clock domain and removes short pulses.
// The output follows the synchronized input only after that input has
// differed from the output for FILT_CYCLES clocks in a row.
// Assumes that real bus levels last much longer than FILT_CYCLES clocks.
module volsel_line_filter #(
    parameter int FILT_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

    logic             sync1, sync2;
    logic [CNT_W-1:0] cnt;

    // Two-stage synchronizer; the bus idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= line_i;
            sync2 <= sync1;
        end
    end

    // Persistence counter: flip the output only after a stable difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            line_o <= 1'b1;
        end else if (sync2 == line_o) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            cnt    <= '0;
            line_o <= sync2;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: the filtered output only moves toward the level the synchronizer held.
    a_r9_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(sync2) == line_o));
endmodule

// File: rtl/volsel_bus_engine.sv
// Module volsel_bus_engine
// Bit-level I2C target for write frames. It uses filtered SCL/SDA and
// detects START and STOP. It shifts in bytes MSB first, matches the
// address, drives the acknowledge and reports each received byte
// (pointer or data) as a one-cycle pulse.
// Assumes that the inputs are already synchronized and filtered; it
// never stretches SCL and never drives read data.
module volsel_bus_engine
    import volsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    output logic              sda_oe,
    output logic              byte_vld,
    output logic              byte_is_ptr,
    output logic [BYTE_W-1:0] byte_data
);
    bus_state_t          state;
    logic                scl_d, sda_d;
    logic [BYTE_W-1:0]   shreg;
    logic [BITCNT_W-1:0] bit_cnt;
    logic                scl_rise, scl_fall, start_c, stop_c;
    logic                addr_hit;

    // Edge and bus-condition detection on the filtered lines.
    always_comb begin
        scl_rise = scl_f & ~scl_d;
        scl_fall = ~scl_f & scl_d;
        start_c  = scl_f & scl_d & sda_d & ~sda_f;
        stop_c   = scl_f & scl_d & ~sda_d & sda_f;
        addr_hit = (shreg[BYTE_W-1:1] == TARGET_ADDR) && !shreg[0];
    end

    // Previous line levels, for the edge detection above.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Frame sequencing: bit counting, acknowledge and byte reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            sda_oe      <= 1'b0;
            byte_vld    <= 1'b0;
            byte_is_ptr <= 1'b0;
            byte_data   <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (start_c) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_c) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (bit_cnt < BITCNT_W'(BYTE_W)) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_f};
                    end
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (scl_fall) begin
                    if (bit_cnt == BITCNT_W'(BYTE_W)) begin
                        case (state)
                            ST_ADDR: begin
                                sda_oe <= addr_hit;
                                state  <= addr_hit ? ST_PTR : ST_SKIP;
                            end
                            ST_PTR: begin
                                sda_oe      <= 1'b1;
                                byte_vld    <= 1'b1;
                                byte_is_ptr <= 1'b1;
                                byte_data   <= shreg;
                                state       <= ST_DATA;
                            end
                            ST_DATA: begin
                                sda_oe      <= 1'b1;
                                byte_vld    <= 1'b1;
                                byte_is_ptr <= 1'b0;
                                byte_data   <= shreg;
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (bit_cnt == BITCNT_W'(BYTE_W + 1)) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                    end
                end
            end
        end
    end

    // R4: SDA is only driven once a write to this address was accepted.
    a_r4_drive_only_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_PTR || state == ST_DATA));
    // R2: the acknowledge is confined to the ninth-bit window.
    a_r2_ack_window: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (bit_cnt >= BITCNT_W'(BYTE_W)));
    // R5: reported bytes arrive on an SCL falling edge after eight bits.
    a_r5_byte_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> ($past(scl_fall) && $past(bit_cnt) == BITCNT_W'(BYTE_W)));
endmodule

// File: rtl/volsel_regfile.sv
// Module volsel_regfile
// Three control registers with a wrapping write pointer, plus the held
// one-hot source selection. A pointer byte outside the register range
// disables writes until the next pointer byte.
// Assumes byte_vld pulses come from volsel_bus_engine.
module volsel_regfile
    import volsel_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          byte_vld,
    input  logic                          byte_is_ptr,
    input  logic [BYTE_W-1:0]             byte_data,
    output logic [NUM_CH-1:0][BYTE_W-1:0] vol_regs,
    output logic [NUM_SRC-1:0]            src_sel
);
    localparam logic [BYTE_W-1:0] NUM_REGS_B = BYTE_W'(NUM_REGS);
    localparam logic [PTR_W-1:0]  PTR_LAST   = PTR_W'(NUM_REGS - 1);
    localparam logic [PTR_W-1:0]  PTR_SRC    = PTR_W'(REG_SRC);

    logic [BYTE_W-1:0]     regs [NUM_REGS];
    logic [PTR_W-1:0]      ptr;
    logic                  ptr_ok;
    logic [SRC_CODE_W-1:0] src_code;

    assign src_code = byte_data[SRC_CODE_W-1:0];

    // Pointer load, data write, pointer wrap and selector hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i);
            ptr     <= '0;
            ptr_ok  <= 1'b0;
            src_sel <= NUM_SRC'(1) << reg_default(REG_SRC)[SRC_CODE_W-1:0];
        end else if (byte_vld) begin
            if (byte_is_ptr) begin
                ptr_ok <= (byte_data < NUM_REGS_B);
                if (byte_data < NUM_REGS_B) ptr <= byte_data[PTR_W-1:0];
            end else if (ptr_ok) begin
                regs[ptr] <= byte_data;
                ptr       <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
                if (ptr == PTR_SRC && src_code < SRC_CODE_W'(NUM_SRC)) begin
                    src_sel <= NUM_SRC'(1) << src_code;
                end
            end
        end
    end

    // Gain registers exported in channel order.
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_vol_out
            assign vol_regs[c] = regs[c];
        end
    endgenerate

    // R5: the pointer never leaves the register range.
    a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_LAST);
    // R7: exactly one source is enabled at all times.
    a_r7_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_sel) == 1);
    // R8: with an out-of-range pointer, a data byte leaves the registers alone.
    a_r8_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_is_ptr && !ptr_ok) |=> ($stable(vol_regs) && $stable(src_sel)));
endmodule

// File: rtl/volsel_gain_decode.sv
// Module volsel_gain_decode
// Turns one gain register into a step index (0 = +12 dB, 3 dB per step)
// and a mute flag. Codes above the last step mute the channel.
// Assumes the gain code sits in the low VOL_W bits.
module volsel_gain_decode
    import volsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] reg_val,
    output logic [VOL_W-1:0]  step,
    output logic              mute
);
    logic [VOL_W-1:0] code;

    // Range check and step mapping.
    always_comb begin
        code = reg_val[VOL_W-1:0];
        mute = (code > VOL_MAX_CODE);
        step = mute ? '0 : code;
    end

    // R6: an unmuted step index never passes the last gain step.
    a_r6_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        !mute |-> (step <= VOL_MAX_CODE));
endmodule

// File: rtl/volsel_i2c_target.sv
// Module volsel_i2c_target
// Top of the write-only control target: line filters, bus engine,
// register file and per-channel gain decoders.
// Assumes an open-drain SDA pad, where sda_oe=1 pulls the line low.
module volsel_i2c_target
    import volsel_pkg::*;
#(
    parameter int FILT_CYCLES = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [3:0]  vol_a_step,
    output logic        vol_a_mute,
    output logic [3:0]  vol_b_step,
    output logic        vol_b_mute,
    output logic [5:0]  src_sel
);
    logic                          scl_f, sda_f;
    logic                          byte_vld, byte_is_ptr;
    logic [BYTE_W-1:0]             byte_data;
    logic [NUM_CH-1:0][BYTE_W-1:0] vol_regs;
    logic [VOL_W-1:0]              ch_step [NUM_CH];
    logic                          ch_mute [NUM_CH];

    volsel_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    volsel_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    volsel_bus_engine u_engine (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .sda_oe(sda_oe), .byte_vld(byte_vld), .byte_is_ptr(byte_is_ptr),
        .byte_data(byte_data));

    volsel_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld),
        .byte_is_ptr(byte_is_ptr), .byte_data(byte_data),
        .vol_regs(vol_regs), .src_sel(src_sel));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            volsel_gain_decode u_dec (
                .clk(clk), .rst_n(rst_n), .reg_val(vol_regs[c]),
                .step(ch_step[c]), .mute(ch_mute[c]));
        end
    endgenerate

    // Channel outputs in port order.
    assign vol_a_step = ch_step[0];
    assign vol_a_mute = ch_mute[0];
    assign vol_b_step = ch_step[1];
    assign vol_b_mute = ch_mute[1];
endmodule

// File: tb/volsel_i2c_target_bench.sv
// Directed bench: a bus-functional I2C master drives frames; each
// scenario task checks its own results at the ports.
module volsel_i2c_target_bench;
    localparam int Q = 63;   // quarter bit in clocks: SCL stays below 400 kHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [3:0] vol_a_step, vol_b_step;
    logic       vol_a_mute, vol_b_mute;
    logic [5:0] src_sel;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int failures = 0;
    logic mon_en = 1'b0;
    logic saw_drive = 1'b0;
    logic [5:0] exp_sel = 6'b000001;
    int exp_a = 15, exp_b = 15;

    always #5 clk = ~clk;

    volsel_i2c_target u_volsel_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .vol_a_step(vol_a_step), .vol_a_mute(vol_a_mute),
        .vol_b_step(vol_b_step), .vol_b_mute(vol_b_mute), .src_sel(src_sel));

    always @(negedge clk) if (mon_en && sda_oe) saw_drive = 1'b1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected decode from a 4-bit gain code: step then mute.
    function automatic int exp_step(input int code);
        return (code > 8) ? 0 : code;
    endfunction

    task automatic check_outputs(input string tag);
        chk(vol_a_step == 4'(exp_step(exp_a)), {tag, " A step"}, vol_a_step, exp_step(exp_a));
        chk(vol_a_mute == (exp_a > 8), {tag, " A mute"}, vol_a_mute, int'(exp_a > 8));
        chk(vol_b_step == 4'(exp_step(exp_b)), {tag, " B step"}, vol_b_step, exp_step(exp_b));
        chk(vol_b_mute == (exp_b > 8), {tag, " B mute"}, vol_b_mute, int'(exp_b > 8));
        chk(src_sel == exp_sel, {tag, " src_sel"}, src_sel, exp_sel);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    // One byte MSB first plus the acknowledge clock; glitch adds spikes.
    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch) begin
                wq(Q / 2); scl_m = 1'b1; wq(5); scl_m = 1'b0; wq(Q - Q / 2 - 5);
            end else wq(Q);
            scl_m = 1'b1; wq(Q);
            if (glitch && b[i]) begin
                sda_m = 1'b0; wq(5); sda_m = 1'b1; wq(Q - 5);
            end else wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q / 2);
        acked = (sda_line == 1'b0);
        wq(Q - Q / 2 + Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        check_outputs("R1 reset");
    endtask

    task automatic t_single_write();
        bit ack;
        bus_start();
        send_byte(8'h82, 0, ack); chk(ack, "R2 address ack", ack, 1);
        send_byte(8'h00, 0, ack); chk(ack, "R11 pointer ack", ack, 1);
        send_byte(8'h03, 0, ack); chk(ack, "R11 data ack", ack, 1);
        bus_stop();
        exp_a = 3;
        check_outputs("R5 single write A");
        bus_start();
        send_byte(8'h82, 0, ack);
        send_byte(8'h01, 0, ack);
        send_byte(8'hF8, 0, ack);
        bus_stop();
        exp_b = 8;
        check_outputs("R6 B code 8 upper bits set");
    endtask

    task automatic t_burst();
        bit ack;
        bus_start();
        send_byte(8'h82, 0, ack);
        send_byte(8'h01, 0, ack);
        send_byte(8'h02, 0, ack); chk(ack, "R11 burst byte1 ack", ack, 1);
        send_byte(8'h05, 0, ack); chk(ack, "R11 burst byte2 ack", ack, 1);
        send_byte(8'h07, 0, ack); chk(ack, "R11 burst byte3 ack", ack, 1);
        send_byte(8'h0A, 0, ack); chk(ack, "R11 burst byte4 ack", ack, 1);
        bus_stop();
        exp_b = 10; exp_sel = 6'b100000; exp_a = 7;
        check_outputs("R5 burst wrap");
    endtask

    // Triplets A, B, selector in one long burst, checked after each byte.
    task automatic t_decode_sweep();
        bit ack;
        bus_start();
        send_byte(8'h82, 0, ack);
        send_byte(8'h00, 0, ack);
        for (int k = 0; k < 8; k++) begin
            send_byte(8'h50 | 8'(k), 0, ack); exp_a = k;
            send_byte(8'hA0 | 8'(k + 8), 0, ack); exp_b = k + 8;
            check_outputs("R6 gain sweep");
            send_byte(8'hF8 | 8'(k), 0, ack);
            if (k < 6) exp_sel = 6'(1 << k);
            check_outputs("R7 selector sweep");
        end
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        bit ack;
        bus_start();
        send_byte(8'h84, 0, ack); chk(!ack, "R3 foreign address nack", ack, 0);
        send_byte(8'h00, 0, ack); chk(!ack, "R3 foreign byte nack", ack, 0);
        bus_stop();
        check_outputs("R3 unchanged");
    endtask

    task automatic t_read();
        bit ack;
        saw_drive = 1'b0; mon_en = 1'b1;
        bus_start();
        send_byte(8'h83, 0, ack); chk(!ack, "R4 read nack", ack, 0);
        send_byte(8'h00, 0, ack);
        bus_stop();
        mon_en = 1'b0;
        chk(!saw_drive, "R4 no SDA drive", saw_drive, 0);
        check_outputs("R4 unchanged");
    endtask

    task automatic t_bad_ptr();
        bit ack;
        bus_start();
        send_byte(8'h82, 0, ack);
        send_byte(8'h03, 0, ack); chk(ack, "R8 bad pointer ack", ack, 1);
        send_byte(8'h00, 0, ack); chk(ack, "R8 discarded data ack", ack, 1);
        send_byte(8'h01, 0, ack);
        bus_stop();
        check_outputs("R8 discarded");
    endtask

    task automatic t_repeated_start();
        bit ack;
        bus_start();
        send_byte(8'h82, 0, ack);
        send_byte(8'h00, 0, ack);
        send_byte(8'h04, 0, ack);
        exp_a = 4;
        bus_start();
        send_byte(8'h82, 0, ack); chk(ack, "R10 re-address ack", ack, 1);
        send_byte(8'h02, 0, ack);
        send_byte(8'h01, 0, ack);
        bus_stop();
        exp_sel = 6'b000010;
        check_outputs("R10 repeated start");
    endtask

    task automatic t_glitch();
        bit ack;
        bus_start();
        send_byte(8'h82, 1, ack); chk(ack, "R9 glitched address ack", ack, 1);
        send_byte(8'h01, 1, ack);
        send_byte(8'hF5, 1, ack);
        bus_stop();
        exp_b = 5;
        check_outputs("R9 glitched write");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wq(10);
        rst_n = 1'b1;
        wq(20);
        t_reset();
        t_single_write();
        t_burst();
        t_decode_sweep();
        t_wrong_addr();
        t_read();
        t_bad_ptr();
        t_repeated_start();
        t_glitch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule